// File: doc/BRIEF.md
# Remote Reader Lease Table

This block keeps a small, fixed set of slots that describe the remote readers currently matched to a local writer. Each occupied slot holds the reader's identifier, whether it is served reliably or best-effort, and the moment at which its lease runs out. A lease deadline is the event time plus a fixed lease duration, which is one second by default. Time is a seconds count together with a binary fraction of a second.

Upstream logic delivers readers that are already decoded, as identifier, kind and strobe. A match request claims a slot. An unmatch request frees one. An acknowledgement event from a reliable reader renews its lease. Whenever the wall-clock input changes, a scan state machine walks the slots one per cycle and drops every reliable reader whose deadline has been reached. Best-effort readers are never dropped by the scan. A combinational read port and an idle flag let surrounding logic or a checker inspect the slots once the scan has settled.

The scan machine has two states. In `ST_IDLE` the idle flag is high and the input time is copied every cycle. The transition `ST_IDLE -> ST_SCAN` is taken when the input time differs from the copy. `ST_SCAN -> ST_SCAN` steps the slot index. `ST_SCAN -> ST_IDLE` is taken after the last slot has been examined. If the time moved during a scan, the machine scans again after one idle cycle.

Top module: `lease_table`

## Requirements
- R1: After synchronous reset, every slot reads back with `rd_valid` = 0, `idle` is 1 and `match_err` is 0.
- R2: A match request for an identifier not in the table fills the lowest-numbered free slot. The slot then reads back valid, with the given identifier and kind (`match_reliable` 1 = reliable, 0 = best-effort), and a deadline of the current time plus the lease duration (1 s + 0 fraction by default).
- R3: A match request whose identifier is already present rewrites that slot's kind and deadline in place. It takes no second slot and leaves every other slot unchanged.
- R4: A match request for a new identifier while all slots are valid pulses `match_err` high for exactly one cycle, starting the cycle after the request, and leaves the table unchanged.
- R5: A slot freed by expiry or unmatch is reused by the next insertion, lowest index first.
- R6: An acknowledgement whose identifier matches a valid reliable slot sets that slot's deadline to the current time plus the lease duration.
- R7: An acknowledgement whose identifier matches no valid slot, or matches a best-effort slot, changes nothing.
- R8: When the time input changes while idle, `idle` is low from the next cycle for exactly as many cycles as there are slots. The scan removes each valid reliable slot whose deadline is at or below the current time, and every remaining slot keeps its index and contents.
- R9: Best-effort slots are never removed by a scan, however far the time advances.
- R10: An unmatch request whose identifier matches a valid slot makes that slot read back invalid.
- R11: When an event writes the slot being examined by the scan in the same cycle, the event wins. An acknowledgement in that cycle renews the lease and the slot stays valid even though its old deadline had passed.
- R12: Only one event is serviced per cycle, with match above unmatch above acknowledgement. Lower-ranked strobes in the same cycle are dropped.
- R13: Expiry uses "time greater than or equal to deadline". A reader is kept when the time is one fraction unit before its deadline and removed when the time equals it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| now_sec | input | SEC_W | Wall-clock time, whole seconds |
| now_frac | input | FRAC_W | Wall-clock time, binary fraction of a second |
| match_vld | input | 1 | Match request strobe |
| match_id | input | ID_W | Identifier of the reader to match |
| match_reliable | input | 1 | Kind of the reader to match: 1 reliable, 0 best-effort |
| unmatch_vld | input | 1 | Unmatch request strobe |
| unmatch_id | input | ID_W | Identifier of the reader to remove |
| ack_vld | input | 1 | Acknowledgement event strobe |
| ack_id | input | ID_W | Identifier of the acknowledging reader |
| match_err | output | 1 | One-cycle pulse: match rejected, table full |
| idle | output | 1 | High while no expiry scan is running |
| rd_idx | input | IDX_W | Slot index to inspect |
| rd_valid | output | 1 | Selected slot holds a matched reader |
| rd_id | output | ID_W | Identifier in the selected slot |
| rd_reliable | output | 1 | Kind in the selected slot |
| rd_dl_sec | output | SEC_W | Deadline seconds of the selected slot |
| rd_dl_frac | output | FRAC_W | Deadline fraction of the selected slot |

## Verification
The interesting collision is an expiry removal and a lease renewal landing on the same slot in the same clock. The bench moves the time past a reliable reader's deadline. It counts edges from the time change so that an acknowledgement for the last slot is presented exactly in the cycle the scan examines that slot. The design is judged correct only if the slot is still valid afterwards and carries the renewed deadline, while an earlier slot that expired in the same scan reads back invalid. A second same-cycle case raises match, unmatch and acknowledgement strobes together and confirms that only the insertion took effect.

// File: rtl/lease_pkg.sv
package lease_pkg;

    // Expiry scan machine states
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_t;

    // Event serviced in the current cycle, in priority order
    typedef enum logic [1:0] {
        EV_NONE    = 2'd0,
        EV_MATCH   = 2'd1,
        EV_UNMATCH = 2'd2,
        EV_ACK     = 2'd3
    } event_kind_t;

endpackage

// File: rtl/lease_deadline_calc.sv
module lease_deadline_calc #(
    parameter int SEC_W      = 32,
    parameter int FRAC_W     = 32,
    parameter int LEASE_SEC  = 1,
    parameter int LEASE_FRAC = 0
) (
    input  logic [SEC_W-1:0]  now_sec,
    input  logic [FRAC_W-1:0] now_frac,
    output logic [SEC_W-1:0]  dl_sec,
    output logic [FRAC_W-1:0] dl_frac
);

    logic [FRAC_W:0] frac_sum;

    always_comb begin
        frac_sum = {1'b0, now_frac} + (FRAC_W+1)'(LEASE_FRAC);
        dl_frac  = frac_sum[FRAC_W-1:0];
        dl_sec   = now_sec + SEC_W'(LEASE_SEC) + SEC_W'(frac_sum[FRAC_W]);
    end

endmodule

// File: rtl/lease_id_lookup.sv
module lease_id_lookup #(
    parameter int SLOTS = 3,
    parameter int ID_W  = 16,
    parameter int IDX_W = 2
) (
    input  logic [SLOTS-1:0]           slot_vld,
    input  logic [SLOTS-1:0][ID_W-1:0] slot_id,
    input  logic [ID_W-1:0]            key,
    output logic                       hit,
    output logic [IDX_W-1:0]           hit_idx,
    output logic                       free_any,
    output logic [IDX_W-1:0]           free_idx
);

    // Walk downwards so the lowest matching index is the one that remains
    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        free_any = 1'b0;
        free_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (slot_vld[i] && (slot_id[i] == key)) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (!slot_vld[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/lease_scan_fsm.sv
module lease_scan_fsm
    import lease_pkg::*;
#(
    parameter int SLOTS = 3,
    parameter int IDX_W = 2,
    parameter int TW    = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TW-1:0]    now_cat,
    output logic             scan_act,
    output logic [IDX_W-1:0] scan_idx,
    output logic             idle
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

    scan_state_t      state, state_nx;
    logic [TW-1:0]    seen_now;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (now_cat != seen_now) state_nx = ST_SCAN;
            ST_SCAN: if (scan_idx == LAST_IDX) state_nx = ST_IDLE;
        endcase
    end

    // Slot pointer and captured time: copied every idle cycle, frozen during a scan
    always_ff @(posedge clk) begin
        if (rst) begin
            scan_idx <= '0;
            seen_now <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    scan_idx <= '0;
                    seen_now <= now_cat;
                end
                ST_SCAN: begin
                    if (scan_idx != LAST_IDX) scan_idx <= scan_idx + 1'b1;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        idle     = 1'b0;
        scan_act = 1'b0;
        unique case (state)
            ST_IDLE: idle     = 1'b1;
            ST_SCAN: scan_act = 1'b1;
        endcase
    end

endmodule

// File: rtl/lease_table.sv
module lease_table
    import lease_pkg::*;
#(
    parameter  int SLOTS      = 3,
    parameter  int ID_W       = 16,
    parameter  int SEC_W      = 32,
    parameter  int FRAC_W     = 32,
    parameter  int LEASE_SEC  = 1,
    parameter  int LEASE_FRAC = 0,
    localparam int IDX_W      = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int TW         = SEC_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEC_W-1:0]  now_sec,
    input  logic [FRAC_W-1:0] now_frac,
    input  logic              match_vld,
    input  logic [ID_W-1:0]   match_id,
    input  logic              match_reliable,
    input  logic              unmatch_vld,
    input  logic [ID_W-1:0]   unmatch_id,
    input  logic              ack_vld,
    input  logic [ID_W-1:0]   ack_id,
    output logic              match_err,
    output logic              idle,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [ID_W-1:0]   rd_id,
    output logic              rd_reliable,
    output logic [SEC_W-1:0]  rd_dl_sec,
    output logic [FRAC_W-1:0] rd_dl_frac
);

    // Slot storage
    logic [SLOTS-1:0]           slot_vld;
    logic [SLOTS-1:0]           slot_rel;
    logic [SLOTS-1:0][ID_W-1:0] slot_id;
    logic [SLOTS-1:0][TW-1:0]   slot_dl;

    logic [TW-1:0]     now_cat;
    logic [SEC_W-1:0]  new_dl_sec;
    logic [FRAC_W-1:0] new_dl_frac;
    logic [TW-1:0]     new_dl;

    assign now_cat = {now_sec, now_frac};
    assign new_dl  = {new_dl_sec, new_dl_frac};

    lease_deadline_calc #(
        .SEC_W      (SEC_W),
        .FRAC_W     (FRAC_W),
        .LEASE_SEC  (LEASE_SEC),
        .LEASE_FRAC (LEASE_FRAC)
    ) u_calc (
        .now_sec  (now_sec),
        .now_frac (now_frac),
        .dl_sec   (new_dl_sec),
        .dl_frac  (new_dl_frac)
    );

    // Event selection: match > unmatch > acknowledgement
    event_kind_t     ev_kind;
    logic [ID_W-1:0] ev_key;

    always_comb begin
        if (match_vld) begin
            ev_kind = EV_MATCH;
            ev_key  = match_id;
        end else if (unmatch_vld) begin
            ev_kind = EV_UNMATCH;
            ev_key  = unmatch_id;
        end else if (ack_vld) begin
            ev_kind = EV_ACK;
            ev_key  = ack_id;
        end else begin
            ev_kind = EV_NONE;
            ev_key  = '0;
        end
    end

    logic             lk_hit;
    logic [IDX_W-1:0] lk_hit_idx;
    logic             lk_free;
    logic [IDX_W-1:0] lk_free_idx;

    lease_id_lookup #(
        .SLOTS (SLOTS),
        .ID_W  (ID_W),
        .IDX_W (IDX_W)
    ) u_lookup (
        .slot_vld (slot_vld),
        .slot_id  (slot_id),
        .key      (ev_key),
        .hit      (lk_hit),
        .hit_idx  (lk_hit_idx),
        .free_any (lk_free),
        .free_idx (lk_free_idx)
    );

    // Decoded slot write for the serviced event
    logic             ev_set_vld;
    logic             ev_vld_val;
    logic             ev_set_id;
    logic             ev_set_dl;
    logic [IDX_W-1:0] ev_slot;
    logic             ev_err;
    logic             ev_touch;

    always_comb begin
        ev_set_vld = 1'b0;
        ev_vld_val = 1'b0;
        ev_set_id  = 1'b0;
        ev_set_dl  = 1'b0;
        ev_slot    = '0;
        ev_err     = 1'b0;
        unique case (ev_kind)
            EV_NONE: begin
            end
            EV_MATCH: begin
                if (lk_hit) begin
                    ev_slot    = lk_hit_idx;
                    ev_set_vld = 1'b1;
                    ev_vld_val = 1'b1;
                    ev_set_id  = 1'b1;
                    ev_set_dl  = 1'b1;
                end else if (lk_free) begin
                    ev_slot    = lk_free_idx;
                    ev_set_vld = 1'b1;
                    ev_vld_val = 1'b1;
                    ev_set_id  = 1'b1;
                    ev_set_dl  = 1'b1;
                end else begin
                    ev_err = 1'b1;
                end
            end
            EV_UNMATCH: begin
                if (lk_hit) begin
                    ev_slot    = lk_hit_idx;
                    ev_set_vld = 1'b1;
                    ev_vld_val = 1'b0;
                end
            end
            EV_ACK: begin
                if (lk_hit && slot_rel[lk_hit_idx]) begin
                    ev_slot   = lk_hit_idx;
                    ev_set_dl = 1'b1;
                end
            end
        endcase
        ev_touch = ev_set_vld | ev_set_dl;
    end

    // Expiry scan
    logic             scan_act;
    logic [IDX_W-1:0] scan_idx;
    logic             expire_now;

    lease_scan_fsm #(
        .SLOTS (SLOTS),
        .IDX_W (IDX_W),
        .TW    (TW)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .now_cat  (now_cat),
        .scan_act (scan_act),
        .scan_idx (scan_idx),
        .idle     (idle)
    );

    // A same-cycle event on the scanned slot overrides the removal
    always_comb begin
        expire_now = scan_act
                   && slot_vld[scan_idx]
                   && slot_rel[scan_idx]
                   && (now_cat >= slot_dl[scan_idx])
                   && !(ev_touch && (ev_slot == scan_idx));
    end

    // Slot update
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_vld  <= '0;
            slot_rel  <= '0;
            slot_id   <= '0;
            slot_dl   <= '0;
            match_err <= 1'b0;
        end else begin
            match_err <= ev_err;
            if (expire_now) begin
                slot_vld[scan_idx] <= 1'b0;
            end
            if (ev_set_vld) begin
                slot_vld[ev_slot] <= ev_vld_val;
            end
            if (ev_set_id) begin
                slot_id[ev_slot]  <= match_id;
                slot_rel[ev_slot] <= match_reliable;
            end
            if (ev_set_dl) begin
                slot_dl[ev_slot] <= new_dl;
            end
        end
    end

    // Inspection port
    always_comb begin
        rd_valid    = 1'b0;
        rd_id       = '0;
        rd_reliable = 1'b0;
        rd_dl_sec   = '0;
        rd_dl_frac  = '0;
        if (int'(rd_idx) < SLOTS) begin
            rd_valid    = slot_vld[rd_idx];
            rd_id       = slot_id[rd_idx];
            rd_reliable = slot_rel[rd_idx];
            rd_dl_sec   = slot_dl[rd_idx][TW-1:FRAC_W];
            rd_dl_frac  = slot_dl[rd_idx][FRAC_W-1:0];
        end
    end

endmodule

// File: rtl/lease_table_chk.sv
module lease_table_chk #(
    parameter int SLOTS  = 3,
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              idle,
    input logic              match_vld,
    input logic              unmatch_vld,
    input logic              match_err,
    input logic              hit_any,
    input logic [SEC_W-1:0]  now_sec,
    input logic [FRAC_W-1:0] now_frac,
    input logic [SLOTS-1:0]  slot_vld,
    input logic [SLOTS-1:0]  slot_rel
);

    localparam int CW = $clog2(SLOTS + 2) + 1;

    logic [CW-1:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_run <= '0;
        end else if (!idle) begin
            busy_run <= busy_run + 1'b1;
        end else begin
            busy_run <= '0;
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (idle && (slot_vld == '0) && !match_err)); // R1

    AST_ERR_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
        match_err |-> ($past(match_vld) && ($past(slot_vld) == '1) && !$past(hit_any))); // R4

    AST_SCAN_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        busy_run <= CW'(SLOTS)); // R8

    AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (rst)
        ($past(idle) && idle && ({now_sec, now_frac} != $past({now_sec, now_frac}))) |=> !idle); // R8

    AST_ONE_INSERT: assert property (@(posedge clk) disable iff (rst)
        $countones(slot_vld & ~$past(slot_vld)) <= 1); // R12

    for (genvar g = 0; g < SLOTS; g++) begin : g_be
        AST_BE_KEEP: assert property (@(posedge clk) disable iff (rst)
            ($fell(slot_vld[g]) && !$past(slot_rel[g])) |-> $past(unmatch_vld)); // R9
    end

endmodule

bind lease_table lease_table_chk #(
    .SLOTS  (SLOTS),
    .SEC_W  (SEC_W),
    .FRAC_W (FRAC_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .idle        (idle),
    .match_vld   (match_vld),
    .unmatch_vld (unmatch_vld),
    .match_err   (match_err),
    .hit_any     (lk_hit),
    .now_sec     (now_sec),
    .now_frac    (now_frac),
    .slot_vld    (slot_vld),
    .slot_rel    (slot_rel)
);

// File: tb/tb_lease_table.sv
`timescale 1ns/1ps
module tb_lease_table;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] now_sec = '0;
    logic [31:0] now_frac = '0;
    logic        match_vld = 1'b0;
    logic [15:0] match_id = '0;
    logic        match_reliable = 1'b0;
    logic        unmatch_vld = 1'b0;
    logic [15:0] unmatch_id = '0;
    logic        ack_vld = 1'b0;
    logic [15:0] ack_id = '0;
    logic        match_err;
    logic        idle;
    logic [1:0]  rd_idx = '0;
    logic        rd_valid;
    logic [15:0] rd_id;
    logic        rd_reliable;
    logic [31:0] rd_dl_sec;
    logic [31:0] rd_dl_frac;

    always #2 clk = ~clk;

    lease_table dut (
        .clk            (clk),
        .rst            (rst),
        .now_sec        (now_sec),
        .now_frac       (now_frac),
        .match_vld      (match_vld),
        .match_id       (match_id),
        .match_reliable (match_reliable),
        .unmatch_vld    (unmatch_vld),
        .unmatch_id     (unmatch_id),
        .ack_vld        (ack_vld),
        .ack_id         (ack_id),
        .match_err      (match_err),
        .idle           (idle),
        .rd_idx         (rd_idx),
        .rd_valid       (rd_valid),
        .rd_id          (rd_id),
        .rd_reliable    (rd_reliable),
        .rd_dl_sec      (rd_dl_sec),
        .rd_dl_frac     (rd_dl_frac)
    );

    localparam logic [15:0] ID_A = 16'h00A1, ID_B = 16'h00B2, ID_C = 16'h00C3,
                            ID_D = 16'h00D4, ID_E = 16'h00E5, ID_F = 16'h00F6,
                            ID_X = 16'h0055;

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        int          idx;
        bit          vld;
        logic [15:0] id;
        bit          rel;
        logic [63:0] dl;
        string       req;
    } exp_t;

    exp_t sb[$];

    task automatic chk(input bit ok, input string req, input string act, input string exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %s expected %s", req, act, exp);
        end
    endtask

    // Driver side: queue expected slot contents
    task automatic exp_slot(input int idx, input bit vld, input logic [15:0] id,
                            input bit rel, input logic [31:0] s, input logic [31:0] f,
                            input string req);
        exp_t e;
        e.idx = idx; e.vld = vld; e.id = id; e.rel = rel; e.dl = {s, f}; e.req = req;
        sb.push_back(e);
    endtask

    task automatic drain();
        wait (sb.size() == 0);
        @(posedge clk);
    endtask

    // Monitor: pops expectations and compares through the read port
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                rd_idx = e.idx[1:0];
                #0.2;
                if (!e.vld) begin
                    chk(rd_valid == 1'b0, e.req, $sformatf("slot%0d vld=%0b", e.idx, rd_valid),
                        "vld=0");
                end else begin
                    chk(rd_valid && rd_id == e.id && rd_reliable == e.rel &&
                        {rd_dl_sec, rd_dl_frac} == e.dl, e.req,
                        $sformatf("slot%0d vld=%0b id=%h rel=%0b dl=%h", e.idx, rd_valid,
                                  rd_id, rd_reliable, {rd_dl_sec, rd_dl_frac}),
                        $sformatf("vld=1 id=%h rel=%0b dl=%h", e.id, e.rel, e.dl));
                end
            end
        end
    end

    task automatic do_match(input logic [15:0] id, input bit rel);
        @(negedge clk);
        match_vld = 1'b1; match_id = id; match_reliable = rel;
        @(negedge clk);
        match_vld = 1'b0;
    endtask

    task automatic do_ack(input logic [15:0] id);
        @(negedge clk);
        ack_vld = 1'b1; ack_id = id;
        @(negedge clk);
        ack_vld = 1'b0;
    endtask

    task automatic do_unmatch(input logic [15:0] id);
        @(negedge clk);
        unmatch_vld = 1'b1; unmatch_id = id;
        @(negedge clk);
        unmatch_vld = 1'b0;
    endtask

    task automatic wait_idle();
        while (!idle) @(posedge clk);
        #1;
    endtask

    task automatic set_time(input logic [31:0] s, input logic [31:0] f);
        @(negedge clk);
        now_sec = s; now_frac = f;
        @(posedge clk);
        #1;
        wait_idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int busy;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0.5;
        // R1: reset state
        chk(idle == 1'b1, "R1", $sformatf("idle=%0b", idle), "1");
        chk(match_err == 1'b0, "R1", $sformatf("err=%0b", match_err), "0");
        for (int i = 0; i < 3; i++) exp_slot(i, 0, '0, 0, 0, 0, "R1");
        drain();

        // R2: inserts fill lowest free slot, deadline = now + 1 s
        do_match(ID_A, 1);
        do_match(ID_B, 0);
        do_match(ID_C, 1);
        exp_slot(0, 1, ID_A, 1, 1, 0, "R2");
        exp_slot(1, 1, ID_B, 0, 1, 0, "R2");
        exp_slot(2, 1, ID_C, 1, 1, 0, "R2");
        drain();

        // R4: full table rejects a new identifier
        @(negedge clk);
        match_vld = 1'b1; match_id = ID_D; match_reliable = 1'b1;
        @(posedge clk); #1;
        chk(match_err == 1'b1, "R4", $sformatf("err=%0b", match_err), "1");
        @(negedge clk);
        match_vld = 1'b0;
        @(posedge clk); #1;
        chk(match_err == 1'b0, "R4", $sformatf("err=%0b", match_err), "0 after one cycle");
        exp_slot(0, 1, ID_A, 1, 1, 0, "R4");
        exp_slot(1, 1, ID_B, 0, 1, 0, "R4");
        exp_slot(2, 1, ID_C, 1, 1, 0, "R4");
        drain();

        // R7: unknown and best-effort acknowledgements change nothing
        set_time(0, 32'h4000_0000);
        do_ack(ID_X);
        do_ack(ID_B);
        exp_slot(0, 1, ID_A, 1, 1, 0, "R7");
        exp_slot(1, 1, ID_B, 0, 1, 0, "R7");
        exp_slot(2, 1, ID_C, 1, 1, 0, "R7");
        drain();

        // R6: acknowledgement at 0.5 s renews reliable lease
        set_time(0, 32'h8000_0000);
        do_ack(ID_C);
        exp_slot(2, 1, ID_C, 1, 1, 32'h8000_0000, "R6");
        drain();

        // R13: one fraction unit before the deadline keeps the reader
        set_time(0, 32'hFFFF_FFFF);
        exp_slot(0, 1, ID_A, 1, 1, 0, "R13");
        drain();

        // R8 / R13 / R9: time reaches 1 s, idle drops for exactly SLOTS cycles
        @(negedge clk);
        now_sec = 1; now_frac = 0;
        @(posedge clk); #1;
        busy = 0;
        while (!idle) begin
            busy++;
            @(posedge clk); #1;
        end
        chk(busy == 3, "R8", $sformatf("busy=%0d", busy), "3");
        exp_slot(0, 0, '0, 0, 0, 0, "R13");
        exp_slot(1, 1, ID_B, 0, 1, 0, "R9");
        exp_slot(2, 1, ID_C, 1, 1, 32'h8000_0000, "R8");
        drain();

        // R5: freed slot 0 is reused
        do_match(ID_E, 1);
        exp_slot(0, 1, ID_E, 1, 2, 0, "R5");
        drain();

        // R3: re-match of a present identifier updates in place
        do_match(ID_C, 1);
        exp_slot(2, 1, ID_C, 1, 2, 0, "R3");
        exp_slot(0, 1, ID_E, 1, 2, 0, "R3");
        exp_slot(1, 1, ID_B, 0, 1, 0, "R3");
        drain();

        // R11: acknowledgement in the exact cycle slot 2 is scanned
        @(negedge clk);
        now_sec = 2; now_frac = 0;
        @(posedge clk);   // enters scan
        @(posedge clk);   // slot 0 examined
        @(posedge clk);   // slot 1 examined
        @(negedge clk);
        ack_vld = 1'b1; ack_id = ID_C;
        @(negedge clk);   // slot 2 examined at the edge in between
        ack_vld = 1'b0;
        wait_idle();
        exp_slot(0, 0, '0, 0, 0, 0, "R11");
        exp_slot(1, 1, ID_B, 0, 1, 0, "R11");
        exp_slot(2, 1, ID_C, 1, 3, 0, "R11");
        drain();

        // R12: match, unmatch and ack in one cycle; only the match is serviced
        set_time(2, 32'h4000_0000);
        @(negedge clk);
        match_vld = 1'b1; match_id = ID_F; match_reliable = 1'b1;
        unmatch_vld = 1'b1; unmatch_id = ID_C;
        ack_vld = 1'b1; ack_id = ID_C;
        @(negedge clk);
        match_vld = 1'b0; unmatch_vld = 1'b0; ack_vld = 1'b0;
        exp_slot(0, 1, ID_F, 1, 3, 32'h4000_0000, "R12");
        exp_slot(2, 1, ID_C, 1, 3, 0, "R12");
        drain();

        // R10: unmatch clears a best-effort slot
        do_unmatch(ID_B);
        exp_slot(1, 0, '0, 0, 0, 0, "R10");
        exp_slot(0, 1, ID_F, 1, 3, 32'h4000_0000, "R10");
        drain();

        // R5: the slot freed by unmatch is taken next
        do_match(ID_D, 0);
        exp_slot(1, 1, ID_D, 0, 3, 32'h4000_0000, "R5");
        drain();

        // R9: far time step leaves the best-effort reader, drops reliable ones
        set_time(100, 0);
        exp_slot(0, 0, '0, 0, 0, 0, "R8");
        exp_slot(1, 1, ID_D, 0, 3, 32'h4000_0000, "R9");
        exp_slot(2, 0, '0, 0, 0, 0, "R8");
        drain();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule